// File: doc/BRIEF.md
# Critical-word-first refill buffer

This block sits between a cache and a burst memory bus and gathers one cache line during a refill. When the cache reports a miss, the block takes the line number and the index of the word that missed. It issues a single request for a four-beat burst whose start address points at that word. Each returned 32-bit beat is written into a four-entry line buffer. Every entry carries its own valid flag.

The first beat is always the word that missed. As soon as it lands, the block forwards it to the requester with a one-cycle pulse and drops the stall. The remaining three beats then fill in the background, in wrap-around order. When the fourth beat has been captured, the block gives a one-cycle completion pulse with the whole line and all four valid flags, ready to be written into the cache arrays. While a burst is in flight the block reports busy and ignores further miss requests.

Top module: `cwf_refill_buf`

## Requirements
- R1: After reset, busy_o, stall_o, bus_req_o, crit_valid_o and line_done_o are 0 and line_valid_o is 4'b0000.
- R2: A miss_req_i seen while busy_o is 0 is accepted. In the next cycle bus_req_o is 1 for exactly one cycle, and bus_addr_o equals {miss_line_i, miss_word_i, 2'b00}.
- R3: Beat k of the burst (k = 0..3, counted over cycles with bus_beat_valid_i high) is stored at word (miss_word_i + k) mod 4. Word i occupies line_data_o[32*i+31:32*i]. Idle cycles between beats do not advance the count.
- R4: In the cycle after the first beat is captured, crit_valid_o is 1 for exactly one cycle and crit_data_o equals that beat's data.
- R5: stall_o is 1 from the cycle after a miss is accepted up to, but not including, the cycle in which crit_valid_o pulses. After that it stays 0 until the next miss is accepted.
- R6: Bit i of line_valid_o is set when word i is captured. The flags are cleared when a new miss is accepted, and are not otherwise cleared within a refill. After the first beat exactly bit miss_word_i is set.
- R7: In the cycle after the fourth beat is captured, line_done_o is 1 for exactly one cycle, line_valid_o is 4'b1111 and busy_o is 0.
- R8: busy_o is 1 from the cycle after acceptance through the cycle of the fourth beat. A miss_req_i raised during that time produces no bus_req_o and leaves bus_addr_o unchanged.
- R9: Beats arriving while busy_o is 0 are ignored. They cause no crit_valid_o and no line_done_o pulse, and leave line_valid_o and line_data_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_req_i | input | 1 | Miss request from the cache |
| miss_line_i | input | 28 | Line number of the missing line (address bits 31:4) |
| miss_word_i | input | 2 | Index of the word that missed |
| busy_o | output | 1 | Refill in progress |
| stall_o | output | 1 | Requester must wait for the critical word |
| bus_req_o | output | 1 | One-cycle burst request |
| bus_addr_o | output | 32 | Byte address of the first beat |
| bus_beat_valid_i | input | 1 | A returned beat is present |
| bus_beat_data_i | input | 32 | Returned beat data |
| crit_valid_o | output | 1 | One-cycle pulse: critical word available |
| crit_data_o | output | 32 | Critical word |
| line_done_o | output | 1 | One-cycle pulse: line complete |
| line_addr_o | output | 32 | Byte address of the line (offset bits zero) |
| line_data_o | output | 128 | Line buffer contents, word i at bits 32*i+31:32*i |
| line_valid_o | output | 4 | Per-word valid flags |

## Verification
The hardest case to reach is a miss request, or stray beats, arriving at the edges of a burst's lifetime. One edge is mid-burst, after the stall has already dropped. The other is the idle cycles right after completion, where the flags of the finished line must survive. The directed tasks place a second miss request between the critical beat and the rest of the burst, and insert idle gaps between beats. They then drive beats with no refill open and read back line_valid_o and line_data_o to show that the buffer was untouched. Refills start from each of the four word indices, so every wrap-around rotation is covered.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FILL  = 2'd2
  } fill_state_e;
endpackage

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq #(
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] base_idx_o,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic             first_o,
  output logic             last_o
);
  logic [IDX_W-1:0] cnt_q, base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else if (start_i) begin
      cnt_q  <= '0;
      base_q <= start_idx_i;
    end else if (step_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // wrap-around order: index rolls over modulo BEATS
  assign cur_idx_o  = base_q + cnt_q;
  assign base_idx_o = base_q;
  assign first_o    = (cnt_q == '0);
  assign last_o     = (cnt_q == IDX_W'(BEATS - 1));

  // R3
  wrap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && step_i) |=> (cur_idx_o == IDX_W'($past(cur_idx_o) + 1'b1)));
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
  parameter int WORD_W = 32,
  parameter int BEATS  = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [WORD_W-1:0]       wr_data_i,
  output logic [BEATS*WORD_W-1:0] line_o,
  output logic [BEATS-1:0]        valid_o
);
  for (genvar g = 0; g < BEATS; g++) begin : g_entry
    logic [WORD_W-1:0] data_q;
    logic              vld_q;
    logic              hit;
    assign hit = wr_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr_i) begin
        vld_q  <= 1'b0;
      end else if (hit) begin
        data_q <= wr_data_i;
        vld_q  <= 1'b1;
      end
    end

    assign line_o[g*WORD_W +: WORD_W] = data_q;
    assign valid_o[g] = vld_q;
  end

  // R6
  valid_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ($countones(valid_o) >= $countones($past(valid_o))));

  // R6
  valid_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (valid_o == '0));
endmodule

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic miss_req_i,
  input  logic beat_valid_i,
  input  logic first_beat_i,
  input  logic last_beat_i,
  output logic accept_o,
  output logic capture_o,
  output logic busy_o,
  output logic stall_o,
  output logic bus_req_o,
  output logic crit_pulse_o,
  output logic done_pulse_o
);
  fill_state_e state_q, state_d;
  logic crit_seen_q, crit_q, done_q;

  assign accept_o  = (state_q == ST_IDLE) && miss_req_i;
  assign capture_o = (state_q != ST_IDLE) && beat_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (miss_req_i) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_FILL;
      ST_FILL:  ;
      default:  state_d = ST_IDLE;
    endcase
    if (capture_o && last_beat_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      crit_seen_q <= 1'b0;
      crit_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      crit_q  <= capture_o && first_beat_i;
      done_q  <= capture_o && last_beat_i;
      if (accept_o)                        crit_seen_q <= 1'b0;
      else if (capture_o && first_beat_i)  crit_seen_q <= 1'b1;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign stall_o      = busy_o && !crit_seen_q;
  assign bus_req_o    = (state_q == ST_ISSUE);
  assign crit_pulse_o = crit_q;
  assign done_pulse_o = done_q;

  // R2
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |=> !bus_req_o);

  // R8
  req_only_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> $rose(busy_o));

  // R4
  crit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_pulse_o |=> !crit_pulse_o);

  // R5
  stall_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_pulse_o |-> !stall_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(capture_o && last_beat_i)) |=> busy_o);
endmodule

// File: rtl/cwf_refill_buf.sv
module cwf_refill_buf #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int BEATS  = 4,
  localparam int IDX_W    = $clog2(BEATS),
  localparam int BYTE_OFF = $clog2(WORD_W / 8),
  localparam int LINE_OFF = IDX_W + BYTE_OFF,
  localparam int LINE_W   = ADDR_W - LINE_OFF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    miss_req_i,
  input  logic [LINE_W-1:0]       miss_line_i,
  input  logic [IDX_W-1:0]        miss_word_i,
  output logic                    busy_o,
  output logic                    stall_o,
  output logic                    bus_req_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  input  logic                    bus_beat_valid_i,
  input  logic [WORD_W-1:0]       bus_beat_data_i,
  output logic                    crit_valid_o,
  output logic [WORD_W-1:0]       crit_data_o,
  output logic                    line_done_o,
  output logic [ADDR_W-1:0]       line_addr_o,
  output logic [BEATS*WORD_W-1:0] line_data_o,
  output logic [BEATS-1:0]        line_valid_o
);
  logic             accept, capture, first_beat, last_beat;
  logic [IDX_W-1:0] base_idx, cur_idx;
  logic [LINE_W-1:0] line_q;
  logic [WORD_W-1:0] crit_q;

  cwf_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_req_i   (miss_req_i),
    .beat_valid_i (bus_beat_valid_i),
    .first_beat_i (first_beat),
    .last_beat_i  (last_beat),
    .accept_o     (accept),
    .capture_o    (capture),
    .busy_o       (busy_o),
    .stall_o      (stall_o),
    .bus_req_o    (bus_req_o),
    .crit_pulse_o (crit_valid_o),
    .done_pulse_o (line_done_o)
  );

  cwf_beat_seq #(.BEATS(BEATS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .start_idx_i (miss_word_i),
    .step_i      (capture),
    .base_idx_o  (base_idx),
    .cur_idx_o   (cur_idx),
    .first_o     (first_beat),
    .last_o      (last_beat)
  );

  cwf_line_buf #(.WORD_W(WORD_W), .BEATS(BEATS)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .wr_i      (capture),
    .wr_idx_i  (cur_idx),
    .wr_data_i (bus_beat_data_i),
    .line_o    (line_data_o),
    .valid_o   (line_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      crit_q <= '0;
    end else begin
      if (accept)                line_q <= miss_line_i;
      if (capture && first_beat) crit_q <= bus_beat_data_i;
    end
  end

  assign bus_addr_o  = {line_q, base_idx, {BYTE_OFF{1'b0}}};
  assign line_addr_o = {line_q, {LINE_OFF{1'b0}}};
  assign crit_data_o = crit_q;

  // R7
  done_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> ((&line_valid_o) && !busy_o));

  // R4
  crit_word_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_valid_o |-> ($countones(line_valid_o) == 1));

  // R8
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bus_req_o) |=> $stable(bus_addr_o));
endmodule

// File: tb/cwf_refill_buf_tb.sv
module cwf_refill_buf_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_req = 1'b0;
  logic [27:0]  miss_line = '0;
  logic [1:0]   miss_word = '0;
  logic         busy, stall, bus_req;
  logic [31:0]  bus_addr;
  logic         beat_valid = 1'b0;
  logic [31:0]  beat_data = '0;
  logic         crit_valid, line_done;
  logic [31:0]  crit_data, line_addr;
  logic [127:0] line_data;
  logic [3:0]   line_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cwf_refill_buf dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .miss_req_i       (miss_req),
    .miss_line_i      (miss_line),
    .miss_word_i      (miss_word),
    .busy_o           (busy),
    .stall_o          (stall),
    .bus_req_o        (bus_req),
    .bus_addr_o       (bus_addr),
    .bus_beat_valid_i (beat_valid),
    .bus_beat_data_i  (beat_data),
    .crit_valid_o     (crit_valid),
    .crit_data_o      (crit_data),
    .line_done_o      (line_done),
    .line_addr_o      (line_addr),
    .line_data_o      (line_data),
    .line_valid_o     (line_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] beat_word(input logic [27:0] ln, input int k);
    return {ln[15:0], 8'hb0, 8'(k)};
  endfunction

  task automatic test_reset();
    chk(busy == 0 && stall == 0 && bus_req == 0, "R1 idle", {busy, stall, bus_req}, 0);
    chk(crit_valid == 0 && line_done == 0, "R1 pulses", {crit_valid, line_done}, 0);
    chk(line_valid == 4'b0, "R1 valid", line_valid, 0);
  endtask

  // one full refill; gap inserts an idle cycle before each beat; mid_miss raises a miss after the critical beat
  task automatic do_refill(input logic [27:0] ln, input logic [1:0] cw, input bit gap, input bit mid_miss);
    logic [31:0] exp_addr;
    logic [3:0]  exp_vld;
    exp_addr = {ln, cw, 2'b00};
    exp_vld  = '0;
    @(negedge clk);
    miss_req = 1; miss_line = ln; miss_word = cw;
    @(negedge clk);
    miss_req = 0;
    chk(bus_req == 1, "R2 req", bus_req, 1);
    chk(bus_addr == exp_addr, "R2 addr", bus_addr, exp_addr);
    chk(stall == 1, "R5 stall set", stall, 1);
    chk(busy == 1, "R8 busy set", busy, 1);
    chk(line_valid == 0, "R6 cleared", line_valid, 0);
    for (int k = 0; k < 4; k++) begin
      if (gap) begin
        @(negedge clk);
        chk(bus_req == 0, "R2 single pulse", bus_req, 0);
        if (k == 0) chk(stall == 1, "R5 stall held", stall, 1);
      end
      beat_valid = 1; beat_data = beat_word(ln, k);
      @(negedge clk);
      beat_valid = 0;
      exp_vld[2'(cw + k)] = 1'b1;
      chk(line_valid == exp_vld, "R6 flags", line_valid, exp_vld);
      if (k == 0) begin
        chk(crit_valid == 1, "R4 crit pulse", crit_valid, 1);
        chk(crit_data == beat_word(ln, 0), "R4 crit data", crit_data, beat_word(ln, 0));
        chk(stall == 0, "R5 stall released", stall, 0);
        if (mid_miss) begin
          miss_req = 1; miss_line = ~ln; miss_word = ~cw;
          @(negedge clk);
          miss_req = 0; miss_line = ln; miss_word = cw;
          chk(bus_req == 0, "R8 no req while busy", bus_req, 0);
          chk(bus_addr == exp_addr, "R8 addr kept", bus_addr, exp_addr);
          chk(stall == 0, "R5 stall stays low", stall, 0);
        end
      end else begin
        chk(crit_valid == 0, "R4 one pulse", crit_valid, 0);
      end
      if (k < 3) begin
        chk(busy == 1, "R8 busy during burst", busy, 1);
        chk(line_done == 0, "R7 no early done", line_done, 0);
      end
    end
    chk(line_done == 1, "R7 done pulse", line_done, 1);
    chk(line_valid == 4'hf, "R7 all valid", line_valid, 4'hf);
    chk(busy == 0, "R7 busy low", busy, 0);
    chk(line_addr == {ln, 4'h0}, "R7 line addr", line_addr, {ln, 4'h0});
    for (int k = 0; k < 4; k++) begin
      int w;
      w = int'(2'(cw + k));
      chk(line_data[32*w +: 32] == beat_word(ln, k), "R3 wrap order",
          line_data[32*w +: 32], beat_word(ln, k));
    end
    @(negedge clk);
    chk(line_done == 0, "R7 one pulse", line_done, 0);
  endtask

  task automatic test_idle_beats();
    logic [127:0] snap_d;
    logic [3:0]   snap_v;
    snap_d = line_data; snap_v = line_valid;
    for (int k = 0; k < 2; k++) begin
      beat_valid = 1; beat_data = 32'hdead_0000 + k;
      @(negedge clk);
      beat_valid = 0;
      chk(crit_valid == 0 && line_done == 0, "R9 no pulse", {crit_valid, line_done}, 0);
      chk(line_valid == snap_v, "R9 flags kept", line_valid, snap_v);
      chk(line_data == snap_d, "R9 data kept", line_data, snap_d);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    test_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    do_refill(28'h123_4567, 2'd0, 1'b0, 1'b0);
    do_refill(28'h0ab_cdef, 2'd1, 1'b1, 1'b0);
    test_idle_beats();
    do_refill(28'hfed_cba9, 2'd2, 1'b0, 1'b1);
    do_refill(28'h555_aaa5, 2'd3, 1'b1, 1'b1);
    test_idle_beats();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule